// File: doc/BRIEF.md
# Protection Configuration Bank with Timed Seal

This block holds the configuration that steers a set of hardware protection detectors: a control register with four per-channel disable bits, and a small set of 8-bit threshold/timing registers. Software writes it over a simple synchronous write port and reads it back through a combinational read port. Each detector input is passed to a fault output unless its disable bit is set.

Software seals the bank so that runaway code cannot change it. Sealing takes two writes to a key register: an arming write, then a sealing write that must arrive within a short window of clock cycles. Once sealed, no register in the bank, the key register included, accepts a write until the next synchronous reset. Each accepted control-register write also opens a guard period of a fixed number of cycles. Further control writes during that period are dropped.

Top module: `prot_lock_bank`

## Requirements
- R1: After reset every register reads 0x00, `dis_o` is 0, `locked_o` is 0 and the key register shows neither armed nor sealed.
- R2: The control register sits at address 0. Bit 2 disables channel 0 (charge over-current), bit 3 channel 1 (discharge over-current), bit 4 channel 2 (short circuit) and bit 5 channel 3 (external input). `dis_o[n]` reflects channel n. Bits 7:6 and 1:0 are not stored and always read as zero.
- R3: `fault_o[n]` equals `detect_i[n]` while `dis_o[n]` is 0 and is held at 0 while `dis_o[n]` is 1.
- R4: A write to the key register (address 1) with data bits [1:0] = 2'b11 arms the seal. While armed, a read of address 1 returns bit 1 set.
- R5: An armed bank seals when a key write with bits [1:0] = 2'b01 arrives on any of the LOCK_WIN (4) clock edges after the arming write. `locked_o` rises on that edge and a read of address 1 returns bit 0 set.
- R6: If no sealing write arrives within LOCK_WIN edges, or a key write carries any value other than 2'b01 or 2'b11, the armed state is dropped and the bank stays unsealed. A repeated 2'b11 restarts the window.
- R7: Once sealed, writes to every address are ignored, and further key writes cannot unseal the bank.
- R8: An accepted control write starts a guard of GUARD_CYC cycles. Control writes on the next GUARD_CYC edges are dropped and do not extend the guard. A control write on the edge after that is accepted.
- R9: Addresses 2 to 2+NUM_THR-1 are 8-bit read/write threshold registers. Reads of unmapped addresses return 0x00.
- R10: A synchronous reset returns a sealed bank to the unsealed state, with every register cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Combinational read data |
| detect_i | input | 4 | Raw detector inputs, one per channel |
| dis_o | output | 4 | Channel disable bits from the control register |
| fault_o | output | 4 | Detector inputs after masking |
| locked_o | output | 1 | Bank sealed |

## Verification
The bench builds the block with GUARD_CYC = 6, LOCK_WIN = 4, NUM_THR = 4 and AW = 3. The short guard lets a dropped write on the sixth edge and an accepted write on the seventh edge both fall inside one test. A window of four puts a sealing write on the fourth edge next to one on the fifth. A 3-bit address with four threshold registers leaves addresses 6 and 7 unmapped, so the zero readback of unmapped addresses is exercised as well.

// File: rtl/prot_lock_pkg.sv
`timescale 1ns/1ps
package prot_lock_pkg;

    localparam int DW = 8;
    localparam int NCH = 4;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_KEY  = 1;
    localparam int ADDR_THR0 = 2;

    localparam int BIT_COC = 2;
    localparam int BIT_DOC = 3;
    localparam int BIT_SC  = 4;
    localparam int BIT_EXT = 5;

    localparam logic [1:0] KEY_ARM  = 2'b11;
    localparam logic [1:0] KEY_SEAL = 2'b01;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_ARMED  = 2'd1,
        LK_SEALED = 2'd2
    } lock_state_e;

    // packed so that bit n of the vector is channel n
    typedef struct packed {
        logic ext;
        logic sc;
        logic doc;
        logic coc;
    } prot_dis_t;

    function automatic logic [DW-1:0] ctrl_pack(input prot_dis_t d);
        logic [DW-1:0] v;
        v = '0;
        v[BIT_EXT] = d.ext;
        v[BIT_SC]  = d.sc;
        v[BIT_DOC] = d.doc;
        v[BIT_COC] = d.coc;
        return v;
    endfunction

    function automatic prot_dis_t ctrl_unpack(input logic [DW-1:0] v);
        prot_dis_t d;
        d.ext = v[BIT_EXT];
        d.sc  = v[BIT_SC];
        d.doc = v[BIT_DOC];
        d.coc = v[BIT_COC];
        return d;
    endfunction

endpackage

// File: rtl/prot_lock_fsm.sv
`timescale 1ns/1ps
module prot_lock_fsm
    import prot_lock_pkg::*;
#(
    parameter int LOCK_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [1:0] key_val,
    output logic       armed,
    output logic       sealed
);
    localparam int CW = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_WIN - 1);

    lock_state_e   state;
    logic [CW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LK_OPEN;
            elapsed <= '0;
        end else begin
            case (state)
                LK_OPEN: begin
                    if (key_wr && key_val == KEY_ARM) begin
                        state   <= LK_ARMED;
                        elapsed <= '0;
                    end
                end
                LK_ARMED: begin
                    if (key_wr) begin
                        if (key_val == KEY_SEAL) begin
                            state <= LK_SEALED;
                        end else if (key_val == KEY_ARM) begin
                            elapsed <= '0;
                        end else begin
                            state <= LK_OPEN;
                        end
                    end else if (elapsed == LAST) begin
                        state <= LK_OPEN;
                    end else begin
                        elapsed <= elapsed + 1'b1;
                    end
                end
                LK_SEALED: state <= LK_SEALED;
                default:   state <= LK_OPEN;
            endcase
        end
    end

    assign armed  = (state == LK_ARMED);
    assign sealed = (state == LK_SEALED);

endmodule

// File: rtl/prot_guard_timer.sv
`timescale 1ns/1ps
module prot_guard_timer #(
    parameter int GUARD_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int GW = $clog2(GUARD_CYC + 1);

    logic [GW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= GW'(GUARD_CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/prot_reg_file.sv
`timescale 1ns/1ps
module prot_reg_file
    import prot_lock_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int AW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_we,
    input  logic          ctrl_we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output prot_dis_t     dis,
    output logic [DW-1:0] rd_val
);
    localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);

    prot_dis_t     dis_q;
    logic [DW-1:0] thr_q [NUM_THR];

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= '0;
        end else if (ctrl_we) begin
            dis_q <= ctrl_unpack(wr_data);
        end
    end

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam logic [AW-1:0] A_THIS = AW'(ADDR_THR0 + g);
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q[g] <= '0;
            end else if (bank_we && wr_addr == A_THIS) begin
                thr_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_addr == A_CTRL) begin
            rd_val = ctrl_pack(dis_q);
        end
        for (int i = 0; i < NUM_THR; i++) begin
            if (rd_addr == AW'(ADDR_THR0 + i)) begin
                rd_val = thr_q[i];
            end
        end
    end

    assign dis = dis_q;

endmodule

// File: rtl/prot_lock_bank.sv
`timescale 1ns/1ps
module prot_lock_bank
    import prot_lock_pkg::*;
#(
    parameter int NUM_THR   = 4,
    parameter int AW        = 3,
    parameter int LOCK_WIN  = 4,
    parameter int GUARD_CYC = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic [3:0]    detect_i,
    output logic [3:0]    dis_o,
    output logic [3:0]    fault_o,
    output logic          locked_o
);
    localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_KEY  = AW'(ADDR_KEY);

    logic          lk_armed;
    logic          lk_sealed;
    logic          g_busy;
    logic          bank_we;
    logic          key_wr;
    logic          ctrl_we;
    prot_dis_t     dis;
    logic [DW-1:0] file_rd;

    assign bank_we = wr_en && !lk_sealed;
    assign key_wr  = bank_we && (wr_addr == A_KEY);
    assign ctrl_we = bank_we && (wr_addr == A_CTRL) && !g_busy;

    prot_lock_fsm #(.LOCK_WIN(LOCK_WIN)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (key_wr),
        .key_val (wr_data[1:0]),
        .armed   (lk_armed),
        .sealed  (lk_sealed)
    );

    prot_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .start (ctrl_we),
        .busy  (g_busy)
    );

    prot_reg_file #(.NUM_THR(NUM_THR), .AW(AW)) u_file (
        .clk     (clk),
        .rst     (rst),
        .bank_we (bank_we),
        .ctrl_we (ctrl_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .dis     (dis),
        .rd_val  (file_rd)
    );

    assign dis_o = dis;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_mask
        assign fault_o[ch] = detect_i[ch] & ~dis_o[ch];
    end

    always_comb begin
        if (rd_addr == A_KEY) begin
            rd_data = {6'b0, lk_armed, lk_sealed};
        end else begin
            rd_data = file_rd;
        end
    end

    assign locked_o = lk_sealed;

endmodule

// File: rtl/prot_lock_bank_chk.sv
`timescale 1ns/1ps
module prot_lock_bank_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic [3:0]    dis_o,
    input logic          locked_o,
    input logic          armed,
    input logic          guard_busy
);
    p_seal_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o);

    p_sealed_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> $stable(dis_o));

    p_guard_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(0) && guard_busy) |=> $stable(dis_o));

    p_seal_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(armed && wr_en && wr_addr == AW'(1) && wr_data[1:0] == 2'b01));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == AW'(0)) |-> (rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00));

endmodule

bind prot_lock_bank prot_lock_bank_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .dis_o      (dis_o),
    .locked_o   (locked_o),
    .armed      (lk_armed),
    .guard_busy (g_busy)
);

// File: tb/prot_lock_bank_test.sv
`timescale 1ns/1ps
module prot_lock_bank_test;
    localparam int AW = 3;
    localparam int NT = 4;
    localparam int WIN = 4;
    localparam int GRD = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [3:0]    detect_i = '0;
    logic [3:0]    dis_o;
    logic [3:0]    fault_o;
    logic          locked_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    prot_lock_bank #(.NUM_THR(NT), .AW(AW), .LOCK_WIN(WIN), .GUARD_CYC(GRD)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .detect_i(detect_i),
        .dis_o(dis_o), .fault_o(fault_o), .locked_o(locked_o)
    );

    // behavioural reference: 0 open, 1 armed, 2 sealed
    logic [7:0] m_ctrl;
    logic [7:0] m_thr [NT];
    int m_st, m_el, m_gd;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 8'h00;
            for (int i = 0; i < NT; i++) m_thr[i] = 8'h00;
            m_st = 0; m_el = 0; m_gd = 0;
        end else if (m_st != 2) begin
            bit took;
            took = 1'b0;
            if (wr_en && wr_addr == 0 && m_gd == 0) begin
                m_ctrl = wr_data & 8'h3C;
                took = 1'b1;
            end
            if (wr_en && wr_addr >= 2 && int'(wr_addr) < 2 + NT)
                m_thr[int'(wr_addr) - 2] = wr_data;
            if (took) m_gd = GRD;
            else if (m_gd > 0) m_gd = m_gd - 1;
            if (m_st == 0) begin
                if (wr_en && wr_addr == 1 && wr_data[1:0] == 2'b11) begin m_st = 1; m_el = 0; end
            end else begin
                if (wr_en && wr_addr == 1) begin
                    if (wr_data[1:0] == 2'b01) m_st = 2;
                    else if (wr_data[1:0] == 2'b11) m_el = 0;
                    else m_st = 0;
                end else if (m_el == WIN - 1) m_st = 0;
                else m_el = m_el + 1;
            end
        end
    end

    function automatic logic [7:0] m_read(input int a);
        if (a == 0) return m_ctrl;
        if (a == 1) return {6'b0, m_st == 1, m_st == 2};
        if (a >= 2 && a < 2 + NT) return m_thr[a - 2];
        return 8'h00;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0] ed;
            ed = m_ctrl[5:2];
            chk({4'b0, dis_o}, {4'b0, ed}, "R2 dis_o vs model");
            chk({7'b0, locked_o}, {7'b0, m_st == 2}, "R5 locked_o vs model");
            chk({4'b0, fault_o}, {4'b0, detect_i & ~ed}, "R3 fault_o vs model");
            chk(rd_data, m_read(int'(rd_addr)), "R9 rd_data vs model");
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        step();
        rd_addr = AW'(a);
        #0.5;
        chk(rd_data, exp, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        step();
        // R1 reset state
        chk({7'b0, locked_o}, 8'h00, "R1 locked after reset");
        chk({4'b0, dis_o}, 8'h00, "R1 dis after reset");
        for (int a = 0; a < 6; a++) rd_chk(a, 8'h00, "R1 register after reset");

        // R9 thresholds and unmapped reads
        wr(2, 8'hA5); wr(3, 8'h5A); wr(5, 8'hFF);
        rd_chk(2, 8'hA5, "R9 thr0"); rd_chk(3, 8'h5A, "R9 thr1");
        rd_chk(4, 8'h00, "R9 thr2 untouched"); rd_chk(5, 8'hFF, "R9 thr3");
        wr(6, 8'h77);
        rd_chk(6, 8'h00, "R9 unmapped read");

        // R3 pass-through with no disables
        detect_i = 4'hF; #0.5;
        chk({4'b0, fault_o}, 8'h0F, "R3 unmasked faults");

        // R2/R3/R8 control write then guard
        wr(0, 8'hFF);
        chk({4'b0, dis_o}, 8'h0F, "R2 all disables set");
        chk({4'b0, fault_o}, 8'h00, "R3 all faults masked");
        idle(GRD - 1);
        wr(0, 8'h00);
        chk({4'b0, dis_o}, 8'h0F, "R8 write on last guard edge dropped");
        wr(0, 8'h14);
        chk({4'b0, dis_o}, 8'h05, "R8 write right after guard accepted");
        chk({4'b0, fault_o}, 8'h0A, "R3 partial masking");
        rd_chk(0, 8'h14, "R2 control readback");
        idle(GRD + 2);
        wr(0, 8'hC3);
        rd_chk(0, 8'h00, "R2 reserved bits read zero");

        // R4/R6 window expiry
        rd_addr = AW'(1);
        wr(1, 8'h03);
        #0.5; chk(rd_data, 8'h02, "R4 armed flag");
        idle(WIN);
        wr(1, 8'h01);
        chk({7'b0, locked_o}, 8'h00, "R6 seal after window rejected");
        #0.5; chk(rd_data, 8'h00, "R6 key reg after expiry");

        // R6 wrong pattern cancels
        wr(1, 8'h03); wr(1, 8'h00);
        #0.5; chk(rd_data, 8'h00, "R6 wrong value disarms");
        wr(1, 8'h01);
        chk({7'b0, locked_o}, 8'h00, "R6 no seal after cancel");

        // R6 repeated arm restarts window
        wr(1, 8'h03); idle(2); wr(1, 8'h03); idle(WIN - 1); wr(1, 8'h01);
        chk({7'b0, locked_o}, 8'h01, "R6 re-arm restarts window");
        #0.5; chk(rd_data, 8'h01, "R5 sealed flag readback");

        // R7 sealed bank ignores writes
        wr(0, 8'h3C); wr(2, 8'h00); wr(1, 8'h00); wr(1, 8'h03);
        chk({4'b0, dis_o}, 8'h00, "R7 control frozen");
        chk({7'b0, locked_o}, 8'h01, "R7 seal kept");
        rd_chk(2, 8'hA5, "R7 threshold frozen");

        // R10 reset recovery
        rst = 1'b1; idle(2); rst = 1'b0; step();
        chk({7'b0, locked_o}, 8'h00, "R10 unsealed after reset");
        rd_chk(2, 8'h00, "R10 threshold cleared");

        // R5 seal on first edge of window
        wr(1, 8'h03); wr(1, 8'h01);
        chk({7'b0, locked_o}, 8'h01, "R5 seal on first window edge");
        chk({4'b0, fault_o}, 8'h0F, "R3 faults pass when sealed clear");
        idle(2);
        finish_run();
    end
endmodule